// File: doc/BRIEF.md
# Cascadable Counter with Terminal-Count Reload

This block is a synchronous binary up counter built from identical 8-bit stages that sit side by side in one wide count. Each stage raises an active-low terminal-count flag whenever its own byte reads all ones. A stage above the lowest one may step only while the flags of every stage below it are low and the shared count enable is low. The enable for each upper stage is the OR of the global enable and the flags of all lower stages, so the stages carry into one another with no ripple through their count registers.

A synchronous parallel load writes the whole count from a data input. When the reload-on-terminal-count control is high, a stage that would wrap from all ones loads its byte of the data input instead of returning to zero. The lowest stage then works as a programmable divider. Its flag pulses low once every 256 − P cycles, where P is the loaded byte. For example, P = 0x8F gives a ratio of 113.

Top module: `cnt_chain`

## Requirements
- R1: Driving `rst_n` low clears every count bit to zero at once, without waiting for a clock edge, and leaves all `tc_n` bits high. Release is synchronised through two flops, so counting can begin on the third rising edge after `rst_n` goes high.
- R2: With `ld_en` low and `cnt_en_n` low, the count rises by exactly one on each rising clock edge. This excludes a stage that R7 reloads.
- R3: With `ld_on_tc` low, a stage at 0xFF that is enabled returns to 0x00 on the next edge. The full count wraps from all ones to zero.
- R4: While `cnt_en_n` is high and `ld_en` is low, the count holds its value.
- R5: `tc_n[k]` is low exactly when `cnt_q[8k+7:8k]` is 0xFF, whatever the state of `cnt_en_n`, `ld_en` or `ld_on_tc`.
- R6: `ld_en` high loads `par_din` into `cnt_q` on the next edge. It takes priority over counting and acts whatever the state of `cnt_en_n`.
- R7: With `ld_on_tc` high, an enabled stage at 0xFF loads its byte `par_din[8k+7:8k]` instead of wrapping. Stage 0 then drives `tc_n[0]` low once every 256 − P cycles, where P is `par_din[7:0]`. Examples: 0x8F gives 113, 0xF0 gives 16 and 0x00 gives 256.
- R8: Stage k > 0 holds its byte unless `cnt_en_n` is low and `tc_n[k-1:0]` are all low. Stage k occupies bits 8k+7 down to 8k of `cnt_q` and `par_din`.
- R9: With `ld_on_tc` low, the 32-bit `cnt_q` equals the loaded start value plus the number of enabled edges since the load, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en_n | input | 1 | Active-low count enable for the whole chain |
| ld_en | input | 1 | Synchronous parallel load, active high |
| ld_on_tc | input | 1 | Reload each stage from `par_din` when it would wrap |
| par_din | input | 32 | Parallel load data, one byte per stage |
| cnt_q | output | 32 | Count value, stage 0 in the low byte |
| tc_n | output | 4 | Active-low all-ones flag for each stage |

## Verification
The assertions assume that `ld_en`, `cnt_en_n`, `ld_on_tc` and `par_din` are synchronous to `clk` and stable around the rising edge. They also assume that `rst_n` is released well clear of a clock edge. The bench changes every input on the falling edge and samples results on the next falling edge. It only starts counting after the three-edge reset release has completed. The one asynchronous step it takes is to pull `rst_n` low mid-cycle, in order to check the immediate clear.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_INC  = 2'd1,
    ACT_LOAD = 2'd2
  } cnt_act_e;

  // Priority: parallel load, then (enabled) reload-at-ones or increment, then hold.
  function automatic cnt_act_e pick_action(
    input logic ld_en,
    input logic en_n,
    input logic reload_tc,
    input logic at_ones
  );
    cnt_act_e act;
    if (ld_en)
      act = ACT_LOAD;
    else if (!en_n && reload_tc && at_ones)
      act = ACT_LOAD;
    else if (!en_n)
      act = ACT_INC;
    else
      act = ACT_HOLD;
    return act;
  endfunction

endpackage

// File: rtl/cnt_rst_sync.sv
module cnt_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in)
      sync_q <= '0;
    else
      sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/cnt_tc_decode.sv
module cnt_tc_decode #(
  parameter int W = 8
) (
  input  logic [W-1:0] q,
  output logic         tc_n
);

  assign tc_n = ~(&q);

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_n,
  input  logic         ld_en,
  input  logic         reload_tc,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc_n
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  cnt_act_e     act;

  cnt_tc_decode #(.W(W)) tc_dec_i (
    .q    (q_r),
    .tc_n (tc_n)
  );

  // next-state
  always_comb begin
    act   = pick_action(ld_en, en_n, reload_tc, ~tc_n);
    q_nxt = q_r;
    unique case (act)
      ACT_LOAD: q_nxt = din;
      ACT_INC:  q_nxt = q_r + {{(W-1){1'b0}}, 1'b1};
      default:  q_nxt = q_r;
    endcase
  end

  // register with written-out clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q_r <= '0;
    else if (act != ACT_HOLD)
      q_r <= q_nxt;
  end

  assign q = q_r;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (q == $past(din)));  // R6

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && en_n) |=> $stable(q));  // R4

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !en_n && !(reload_tc && (&q))) |=> (q == $past(q) + 1'b1));  // R2

  AST_RELOAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !en_n && reload_tc && (&q)) |=> (q == $past(din)));  // R7

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !en_n && !reload_tc && (&q)) |=> (q == '0));  // R3

endmodule

// File: rtl/cnt_en_tree.sv
module cnt_en_tree #(
  parameter int N = 4
) (
  input  logic         ext_en_n,
  input  logic [N-1:0] tc_n,
  output logic [N-1:0] stage_en_n
);

  logic [N-1:0] pre_or;

  generate
    for (genvar k = 0; k < N; k++) begin : g_en
      if (k == 0) begin : g_lsb
        assign pre_or[k] = ext_en_n;
      end else begin : g_up
        assign pre_or[k] = pre_or[k-1] | tc_n[k-1];
      end
      assign stage_en_n[k] = pre_or[k];
    end
  endgenerate

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
  parameter int NUM_STAGES = 4,
  parameter int STAGE_W    = 8,
  localparam int TOTAL_W   = NUM_STAGES * STAGE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_en_n,
  input  logic               ld_en,
  input  logic               ld_on_tc,
  input  logic [TOTAL_W-1:0] par_din,
  output logic [TOTAL_W-1:0] cnt_q,
  output logic [NUM_STAGES-1:0] tc_n
);

  logic                  rst_sync_n;
  logic [NUM_STAGES-1:0] stage_en_n;

  cnt_rst_sync #(.SYNC_STAGES(2)) rst_sync_i (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  cnt_en_tree #(.N(NUM_STAGES)) en_tree_i (
    .ext_en_n   (cnt_en_n),
    .tc_n       (tc_n),
    .stage_en_n (stage_en_n)
  );

  generate
    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
      cnt_stage #(.W(STAGE_W)) stage_i (
        .clk       (clk),
        .rst_n     (rst_sync_n),
        .en_n      (stage_en_n[k]),
        .ld_en     (ld_en),
        .reload_tc (ld_on_tc),
        .din       (par_din[k*STAGE_W +: STAGE_W]),
        .q         (cnt_q[k*STAGE_W +: STAGE_W]),
        .tc_n      (tc_n[k])
      );

      if (k > 0) begin : g_chk
        AST_UPPER_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
          (!ld_en && (cnt_en_n || (|tc_n[k-1:0]))) |=> $stable(cnt_q[k*STAGE_W +: STAGE_W]));  // R8
      end
    end
  endgenerate

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_sync_n |-> (cnt_q == '0));  // R1

endmodule

// File: tb/cnt_chain_tb_top.sv
`timescale 1ns/1ps
module cnt_chain_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cnt_en_n;
  logic        ld_en;
  logic        ld_on_tc;
  logic [31:0] par_din;
  logic [31:0] cnt_q;
  logic [3:0]  tc_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  cnt_chain dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en_n (cnt_en_n),
    .ld_en    (ld_en),
    .ld_on_tc (ld_on_tc),
    .par_din  (par_din),
    .cnt_q    (cnt_q),
    .tc_n     (tc_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [31:0] v, input logic en_n_val);
    @(negedge clk);
    ld_en = 1'b1; par_din = v; cnt_en_n = en_n_val;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cnt_en_n = 1'b1; ld_en = 1'b0; ld_on_tc = 1'b0; par_din = '0;
    repeat (3) @(negedge clk);
    chk("R1 count in reset", cnt_q, 32'h0);
    chk("R1 tc_n in reset", {28'h0, tc_n}, 32'hF);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_load(32'hA5A5_5A5A, 1'b1);
    chk("R6 load before async reset", cnt_q, 32'hA5A5_5A5A);
    #3 rst_n = 1'b0;
    #1;
    chk("R1 async clear mid-cycle", cnt_q, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 zero after release", cnt_q, 32'h0);
  endtask

  task automatic t_load_priority;
    do_load(32'h1234_5678, 1'b1);
    chk("R6 load with enable high", cnt_q, 32'h1234_5678);
    do_load(32'h0000_00FF, 1'b0);
    chk("R6 load beats count", cnt_q, 32'h0000_00FF);
  endtask

  task automatic t_hold;
    do_load(32'h0000_00FF, 1'b1);
    repeat (5) @(negedge clk);
    chk("R4 hold with enable high", cnt_q, 32'h0000_00FF);
    chk("R5 tc low at ones while disabled", {31'h0, tc_n[0]}, 32'h0);
    chk("R8 upper stage holds when disabled", {24'h0, cnt_q[15:8]}, 32'h0);
  endtask

  task automatic t_inc;
    do_load(32'h0000_0000, 1'b1);
    cnt_en_n = 1'b0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      chk("R2 increment", cnt_q, i);
    end
    cnt_en_n = 1'b1;
  endtask

  task automatic t_wrap_tc;
    do_load(32'h0000_00FD, 1'b1);
    chk("R5 tc high at 0xFD", {31'h0, tc_n[0]}, 32'h1);
    cnt_en_n = 1'b0;
    @(negedge clk);
    chk("R5 tc high at 0xFE", {31'h0, tc_n[0]}, 32'h1);
    @(negedge clk);
    chk("R5 tc low at 0xFF", {31'h0, tc_n[0]}, 32'h0);
    @(negedge clk);
    chk("R3 byte wraps, R8 carry", cnt_q, 32'h0000_0100);
    cnt_en_n = 1'b1;
  endtask

  task automatic t_wide(input logic [31:0] start, input int ncyc, input bit gaps);
    logic [31:0] ref_v;
    do_load(start, 1'b1);
    ref_v = start;
    for (int i = 0; i < ncyc; i++) begin
      cnt_en_n = (gaps && (i % 3 == 2));
      @(negedge clk);
      if (!cnt_en_n) ref_v = ref_v + 1;
      chk("R9 wide count", cnt_q, ref_v);
    end
    chk("R5 top flag", {28'h0, tc_n}, {28'h0, (cnt_q[31:24] != 8'hFF), (cnt_q[23:16] != 8'hFF),
                                         (cnt_q[15:8] != 8'hFF), (cnt_q[7:0] != 8'hFF)});
    cnt_en_n = 1'b1;
  endtask

  task automatic t_div(input logic [7:0] p, input int ratio);
    int cyc;
    int guard;
    ld_on_tc = 1'b1;
    do_load({24'h0, p}, 1'b1);
    cnt_en_n = 1'b0;
    guard = 0;
    while (tc_n[0] !== 1'b0 && guard < 600) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    chk("R7 reload value", {24'h0, cnt_q[7:0]}, {24'h0, p});
    cyc = 1;
    while (tc_n[0] !== 1'b0 && cyc < 600) begin
      @(negedge clk);
      cyc++;
    end
    chk("R7 divide ratio", cyc, ratio);
    cnt_en_n = 1'b1;
    ld_on_tc = 1'b0;
  endtask

  initial begin
    t_reset();
    t_load_priority();
    t_hold();
    t_inc();
    t_wrap_tc();
    t_wide(32'h00FF_FFF0, 40, 1'b1);
    t_wide(32'hFFFF_FFF8, 16, 1'b0);
    t_div(8'h8F, 113);
    t_div(8'hF0, 16);
    t_div(8'h00, 256);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule